// File: doc/BRIEF.md
# Multi-Source Reset and Watchdog Controller

This block produces the chip-wide reset. Three things can start a reset: the board-level reset input, a software write to a control register, and expiry of a watchdog. Two outputs carry the result. The first is an active-high reset that is synchronous to the system clock and goes to on-chip logic. The second is an active-low reset for devices on the board.

The watchdog is off after power-up, and only software can turn it on. While it is on, it raises an interrupt to the processor at a programmable interval. The processor must acknowledge each interrupt within a programmable window. It can do this on a dedicated input or through a control bit. If no acknowledge arrives in time, the block decides the system is hung and issues a reset.

A status field records which source caused the most recent reset. A software or watchdog reset does not clear this field. A software or watchdog reset does switch the watchdog off again.

Top module: `rstwdt_top`

## Requirements
- R1: The board reset input is synchronized through two flops. While the input is low, the internal reset is high and the board reset output is low, and the status cause field reads 1 (pin). After the input rises, the internal reset falls exactly 18 clock edges later: 2 edges of synchronizer plus 16 edges of hold. A board reset also returns the interval register to 1000 and the window register to 500.
- R2: A write to address 0 with bit 1 set starts a software reset. The internal reset is high from the write edge for exactly 16 cycles. The cause field then reads 2 (software).
- R3: After a board reset the watchdog is disabled, and no interrupt is ever raised until software sets enable (address 0, bit 0).
- R4: The interrupt is a level that rises exactly INTERVAL clock edges after the edge that enables the watchdog. An interval value of 0 acts as 1.
- R5: An acknowledge, given either on the acknowledge input or by writing address 0 with bit 2 set, clears the interrupt at the next edge. The next interrupt then rises INTERVAL edges after the acknowledge edge.
- R6: If the interrupt is still pending WINDOW edges after it rose, a reset starts at that edge and lasts 16 cycles, and the cause field reads 3 (watchdog). An acknowledge sampled on that same edge prevents the reset. A window value of 0 acts as 1.
- R7: A software or watchdog reset clears the enable bit. The interval and window registers keep their values through such a reset.
- R8: Every register write is ignored while the internal reset is high.
- R9: The board reset output is always the inverse of the internal reset.
- R10: Register map. Address 0 is control and reads enable in bit 0. Address 1 is the 16-bit interval. Address 2 is the 16-bit window. Address 3 is status: cause in bits 1:0 and interrupt pending in bit 2. Writes to address 3 have no effect.
- R11: Cause priority is board pin, then watchdog, then software. If a watchdog expiry and a software reset request fall on the same edge, the cause reads 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| extRstN | input | 1 | Board reset input, active low, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 16 | Register read data, combinational |
| wdAck | input | 1 | Interrupt acknowledge pulse from the processor |
| wdIrq | output | 1 | Watchdog interrupt, level |
| sysRst | output | 1 | Internal reset, active high, synchronous |
| extRstOutN | output | 1 | Board reset output, active low |

## Verification
The assertions check the following on every cycle:
- a trigger is followed by reset on the next cycle;
- no reset pulse is shorter than the hold;
- the cause code is correct after each trigger;
- no interrupt is pending while the watchdog is disabled;
- an acknowledge always clears the pending state;
- writes stay frozen during reset;
- the two reset outputs are always complementary.

The exact cycle positions can only be shown by the bench's scenarios. These include interrupt timing swept over many interval and window pairs, the last acknowledge edge that still saves the system, the exact 18-edge release after a board reset, and register contents surviving or being restored.

// File: rtl/rstwdt_pkg.sv
package rstwdt_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_PIN  = 2'd1,
    CAUSE_SW   = 2'd2,
    CAUSE_WD   = 2'd3
  } rstCause_e;

  // strobes from the reset sequencer to the register/timer datapath
  typedef struct packed {
    logic inReset;  // internal reset currently active
    logic clearWd;  // reset active or starting this cycle: drop watchdog state
  } rstStrobe_t;

  localparam logic [1:0] ADDR_CTRL    = 2'd0;
  localparam logic [1:0] ADDR_PERIOD  = 2'd1;
  localparam logic [1:0] ADDR_WINDOW  = 2'd2;
  localparam logic [1:0] ADDR_STATUS  = 2'd3;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_SWRST_BIT = 1;
  localparam int CTRL_ACK_BIT   = 2;
  localparam int STAT_PEND_BIT  = 2;
endpackage

// File: rtl/rstwdt_sync.sv
module rstwdt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic asyncRstN,
  output logic pinRst
);
  // assert asynchronously, release through STAGES flops
  logic [STAGES-1:0] shiftQ;

  always_ff @(posedge clk or negedge asyncRstN) begin
    if (!asyncRstN) shiftQ <= '0;
    else            shiftQ <= {shiftQ[STAGES-2:0], 1'b1};
  end

  assign pinRst = ~shiftQ[STAGES-1];
endmodule

// File: rtl/rstwdt_ctrl.sv
module rstwdt_ctrl
  import rstwdt_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       pinRst,
  input  logic       swReq,
  input  logic       wdExpire,
  output logic       sysRst,
  output logic       extRstOutN,
  output rstCause_e  cause,
  output rstStrobe_t strobe
);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYCLES);
  localparam logic [HOLD_W-1:0] HOLD_MIN  = HOLD_W'(HOLD_CYCLES - 1);

  logic [HOLD_W-1:0] holdQ, holdNext;
  logic              outNQ;
  logic              trigger;
  rstCause_e         causeQ;

  assign trigger = swReq | wdExpire;

  always_comb begin
    if (trigger)            holdNext = HOLD_LOAD;
    else if (holdQ != '0)   holdNext = holdQ - 1'b1;
    else                    holdNext = holdQ;
  end

  always_ff @(posedge clk or posedge pinRst) begin
    if (pinRst) begin
      holdQ  <= HOLD_LOAD;
      outNQ  <= 1'b0;
      causeQ <= CAUSE_PIN;
    end else begin
      holdQ  <= holdNext;
      outNQ  <= (holdNext == '0);
      // watchdog outranks software when both land together
      if (wdExpire)   causeQ <= CAUSE_WD;
      else if (swReq) causeQ <= CAUSE_SW;
    end
  end

  assign sysRst         = (holdQ != '0);
  assign extRstOutN     = outNQ;
  assign cause          = causeQ;
  assign strobe.inReset = sysRst;
  assign strobe.clearWd = sysRst | trigger;

  // length of the current reset pulse, used by the hold check
  logic [HOLD_W-1:0] lenQ;
  always_ff @(posedge clk or posedge pinRst) begin
    if (pinRst)      lenQ <= '0;
    else if (sysRst) lenQ <= (lenQ == HOLD_LOAD) ? lenQ : lenQ + 1'b1;
    else             lenQ <= '0;
  end

  assert_trigger_resets_R2: assert property (@(posedge clk) disable iff (pinRst)
    trigger |=> (sysRst && !extRstOutN));

  assert_min_hold_R2: assert property (@(posedge clk) disable iff (pinRst)
    (!sysRst && $past(sysRst)) |-> ($past(lenQ) >= HOLD_MIN));

  assert_wd_cause_R11: assert property (@(posedge clk) disable iff (pinRst)
    wdExpire |=> (causeQ == CAUSE_WD));

  assert_sw_cause_R2: assert property (@(posedge clk) disable iff (pinRst)
    (swReq && !wdExpire) |=> (causeQ == CAUSE_SW));
endmodule

// File: rtl/rstwdt_dp.sv
module rstwdt_dp
  import rstwdt_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DEF_PERIOD  = 1000,
  parameter int DEF_WINDOW  = 500
) (
  input  logic              clk,
  input  logic              pinRst,
  input  rstStrobe_t        strobe,
  input  rstCause_e         cause,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              wdAck,
  output logic              wdIrq,
  output logic              swReq,
  output logic              wdExpire
);
  localparam int NUM_TIMERS = 2;  // 0: interval, 1: window

  logic              wdEnQ, pendQ;
  logic [DATA_W-1:0] periodQ, windowQ, cntQ;
  logic              wrOk, ctrlWr, ackNow, enNext;

  assign wrOk   = wrEn & ~strobe.inReset;
  assign ctrlWr = wrOk & (wrAddr == ADDR_CTRL);
  assign swReq  = ctrlWr & wrData[CTRL_SWRST_BIT];
  assign ackNow = ~strobe.inReset & (wdAck | (ctrlWr & wrData[CTRL_ACK_BIT]));
  assign enNext = ctrlWr ? wrData[CTRL_EN_BIT] : wdEnQ;

  // terminal counts: a programmed zero behaves as one
  logic [DATA_W-1:0] cfgVal [NUM_TIMERS];
  logic [DATA_W-1:0] limVal [NUM_TIMERS];
  assign cfgVal[0] = periodQ;
  assign cfgVal[1] = windowQ;
  for (genvar g = 0; g < NUM_TIMERS; g++) begin : gLimit
    assign limVal[g] = (cfgVal[g] == '0) ? '0 : cfgVal[g] - 1'b1;
  end

  assign wdExpire = wdEnQ & pendQ & ~ackNow & ~strobe.inReset & (cntQ >= limVal[1]);

  always_ff @(posedge clk or posedge pinRst) begin
    if (pinRst) begin
      periodQ <= DATA_W'(DEF_PERIOD);
      windowQ <= DATA_W'(DEF_WINDOW);
    end else if (wrOk) begin
      if (wrAddr == ADDR_PERIOD) periodQ <= wrData;
      if (wrAddr == ADDR_WINDOW) windowQ <= wrData;
    end
  end

  always_ff @(posedge clk or posedge pinRst) begin
    if (pinRst) begin
      wdEnQ <= 1'b0;
      pendQ <= 1'b0;
      cntQ  <= '0;
    end else if (strobe.clearWd) begin
      wdEnQ <= 1'b0;
      pendQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      wdEnQ <= enNext;
      if (!wdEnQ || !enNext || ackNow) begin
        pendQ <= 1'b0;
        cntQ  <= '0;
      end else if (!pendQ) begin
        if (cntQ >= limVal[0]) begin
          pendQ <= 1'b1;
          cntQ  <= '0;
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end else begin
        cntQ <= cntQ + 1'b1;  // expiry is taken through clearWd
      end
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_CTRL:   rdData[CTRL_EN_BIT] = wdEnQ;
      ADDR_PERIOD: rdData = periodQ;
      ADDR_WINDOW: rdData = windowQ;
      ADDR_STATUS: begin
        rdData[1:0]           = cause;
        rdData[STAT_PEND_BIT] = pendQ;
      end
    endcase
  end

  assign wdIrq = pendQ;

  assert_irq_needs_en_R3: assert property (@(posedge clk) disable iff (pinRst)
    pendQ |-> wdEnQ);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (pinRst)
    ackNow |=> !pendQ);

  assert_reset_disables_R7: assert property (@(posedge clk) disable iff (pinRst)
    strobe.inReset |-> !wdEnQ);

  assert_write_blocked_R8: assert property (@(posedge clk) disable iff (pinRst)
    strobe.inReset |=> ($stable(periodQ) && $stable(windowQ)));
endmodule

// File: rtl/rstwdt_top.sv
module rstwdt_top
  import rstwdt_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 16,
  parameter int DEF_PERIOD  = 1000,
  parameter int DEF_WINDOW  = 500
) (
  input  logic              clk,
  input  logic              extRstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              wdAck,
  output logic              wdIrq,
  output logic              sysRst,
  output logic              extRstOutN
);
  logic       pinRst, swReq, wdExpire;
  rstCause_e  cause;
  rstStrobe_t strobe;

  rstwdt_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk       (clk),
    .asyncRstN (extRstN),
    .pinRst    (pinRst)
  );

  rstwdt_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) uCtrl (
    .clk        (clk),
    .pinRst     (pinRst),
    .swReq      (swReq),
    .wdExpire   (wdExpire),
    .sysRst     (sysRst),
    .extRstOutN (extRstOutN),
    .cause      (cause),
    .strobe     (strobe)
  );

  rstwdt_dp #(
    .DATA_W     (DATA_W),
    .DEF_PERIOD (DEF_PERIOD),
    .DEF_WINDOW (DEF_WINDOW)
  ) uDp (
    .clk      (clk),
    .pinRst   (pinRst),
    .strobe   (strobe),
    .cause    (cause),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .wdAck    (wdAck),
    .wdIrq    (wdIrq),
    .swReq    (swReq),
    .wdExpire (wdExpire)
  );

  assert_out_inverse_R9: assert property (@(posedge clk) disable iff (pinRst)
    extRstOutN == !sysRst);
endmodule

// File: tb/tb_rstwdt_top.sv
module tb_rstwdt_top;
  localparam int HOLD  = 16;
  localparam int SYNC  = 2;
  localparam int DEF_P = 1000;
  localparam int DEF_T = 500;

  logic        clk = 1'b0;
  logic        extRstN = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic [1:0]  rdAddr = 2'd0;
  logic [15:0] rdData;
  logic        wdAck = 1'b0;
  logic        wdIrq, sysRst, extRstOutN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rstwdt_top dut (
    .clk(clk), .extRstN(extRstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .wdAck(wdAck), .wdIrq(wdIrq),
    .sysRst(sysRst), .extRstOutN(extRstOutN)
  );

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step(1);
    wrEn = 1'b0; wrData = 16'd0;
  endtask

  // costs one cycle; only used where the design is idle or frozen
  task automatic rd(input logic [1:0] a, output int v);
    rdAddr = a;
    @(negedge clk);
    v = int'(rdData);
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    int irqSeen;
    int periods[5] = '{1, 2, 3, 5, 8};
    int windows[4] = '{1, 2, 4, 7};

    // R1: board reset and exact release timing
    #1 extRstN = 1'b0;
    step(4);
    check("R1 reset high", sysRst, 1);
    check("R9 out low", extRstOutN, 0);
    check("R3 irq idle", wdIrq, 0);
    extRstN = 1'b1;
    step(SYNC + HOLD - 1);
    check("R1 still held", sysRst, 1);
    step(1);
    check("R1 released", sysRst, 0);
    check("R9 out high", extRstOutN, 1);
    rd(2'd3, v); check("R1 cause pin", v, 1);
    rd(2'd0, v); check("R3 disabled", v, 0);
    rd(2'd1, v); check("R10 interval default", v, DEF_P);
    rd(2'd2, v); check("R10 window default", v, DEF_T);

    // R3: no interrupt without enable
    irqSeen = 0;
    for (int i = 0; i < 1100; i++) begin
      step(1);
      if (wdIrq) irqSeen++;
    end
    check("R3 no irq while disabled", irqSeen, 0);

    // R10: status is read-only
    wr(2'd3, 16'hFFFF);
    rd(2'd3, v); check("R10 status unwritable", v, 1);

    // R4..R7: sweep interval/window pairs
    foreach (periods[pi]) begin
      foreach (windows[ti]) begin
        int p;
        int t;
        p = periods[pi];
        t = windows[ti];
        wr(2'd1, 16'(p));
        wr(2'd2, 16'(t));
        wr(2'd0, 16'h1);
        if (p > 1) begin
          step(p - 1);
          check("R4 irq not yet", wdIrq, 0);
          step(1);
        end else begin
          step(1);
        end
        check("R4 irq at interval", wdIrq, 1);
        // last edge on which the acknowledge still wins
        step(t - 1);
        wdAck = 1'b1;
        step(1);
        wdAck = 1'b0;
        check("R5 port ack clears", wdIrq, 0);
        check("R6 ack on last edge saves", sysRst, 0);
        if (p > 1) begin
          step(p - 1);
          check("R5 irq not yet after ack", wdIrq, 0);
          step(1);
        end else begin
          step(1);
        end
        check("R5 irq interval after ack", wdIrq, 1);
        wr(2'd0, 16'h5);
        check("R5 register ack clears", wdIrq, 0);
        step(p);
        check("R5 irq again", wdIrq, 1);
        if (t > 1) begin
          step(t - 1);
          check("R6 no reset before window", sysRst, 0);
          step(1);
        end else begin
          step(1);
        end
        check("R6 watchdog reset", sysRst, 1);
        check("R9 out low on watchdog", extRstOutN, 0);
        check("R6 irq dropped", wdIrq, 0);
        step(HOLD - 1);
        check("R6 hold", sysRst, 1);
        step(1);
        check("R6 release", sysRst, 0);
        rd(2'd3, v); check("R6 cause watchdog", v, 3);
        rd(2'd0, v); check("R7 enable cleared", v, 0);
        rd(2'd1, v); check("R7 interval kept", v, p);
        rd(2'd2, v); check("R7 window kept", v, t);
      end
    end

    // R2 and R8: software reset, writes during hold ignored
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h1);
    step(1);
    wr(2'd0, 16'h2);
    check("R2 sw reset high", sysRst, 1);
    check("R9 out low on sw", extRstOutN, 0);
    wr(2'd1, 16'd77);
    wr(2'd0, 16'h1);
    step(HOLD - 3);
    check("R2 hold", sysRst, 1);
    step(1);
    check("R2 release", sysRst, 0);
    rd(2'd3, v); check("R2 cause software", v, 2);
    rd(2'd1, v); check("R8 interval write ignored", v, 3);
    rd(2'd0, v); check("R8 enable write ignored", v, 0);

    // R11: watchdog expiry and software request on the same edge
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h1);
    step(2);
    check("R11 irq up", wdIrq, 1);
    step(2);
    wr(2'd0, 16'h2);
    check("R11 reset started", sysRst, 1);
    rd(2'd3, v); check("R11 watchdog wins", v, 3);
    step(HOLD);
    check("R11 released", sysRst, 0);

    // R7: enable written together with software reset stays off
    wr(2'd0, 16'h3);
    step(HOLD);
    rd(2'd0, v); check("R7 enable with sw reset", v, 0);

    // R1 and R11: board reset in mid-operation
    wr(2'd1, 16'd9);
    wr(2'd0, 16'h1);
    step(3);
    extRstN = 1'b0;
    #1;
    check("R1 async assert", sysRst, 1);
    check("R9 out low on pin", extRstOutN, 0);
    step(2);
    rd(2'd3, v); check("R11 pin cause", v, 1);
    rd(2'd1, v); check("R1 interval restored", v, DEF_P);
    extRstN = 1'b1;
    step(SYNC + HOLD - 1);
    check("R1 held again", sysRst, 1);
    step(1);
    check("R1 released again", sysRst, 0);
    rd(2'd0, v); check("R3 disabled after pin", v, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule